// File: doc/BRIEF.md
# NEC Infrared Frame Decoder

This block turns the demodulated output of an infrared receiver into 32-bit NEC frames. The receiver line is active low: a low level is a carrier burst (mark) and a high level is a gap (space). A clean copy of the line comes out of a short glitch filter. The time between its edges is then counted in base ticks. A base tick is one microsecond multiplied by a programmable divider value plus one. Each counted duration is compared against programmable minimum/maximum windows for the leader mark, the data leader space, the repeat leader space, a zero bit period and a one bit period.

A complete data frame loads the 32-bit frame register, updates a four-bit status and raises a one-cycle interrupt. A repeat frame updates only the status. In the status, bit 3 is valid, bit 2 is the data-code error, bit 1 is the custom-code error and bit 0 is repeat. A hold mode keeps a captured frame until the consumer pulses a read strobe. Timing windows, the filter length, the divider, the frame length and the mode bits are static configuration inputs. They normally come from a register bank outside this block.

Top module: `ir_nec_rx`

## Requirements
- R1: Durations are counted in base ticks of (base_div+1) microseconds. A frame sent with every time doubled decodes correctly when base_div is 1.
- R2: A leader mark from ldr_mark_min to ldr_mark_max ticks, inclusive, is accepted. A leader mark outside that range produces no interrupt and returns the decoder to idle.
- R3: A leader space inside the data window starts bit reception. A leader space inside the repeat window raises the interrupt with status 4'b1001 and leaves frame_o unchanged. A leader space in neither window is dropped.
- R4: A fall-to-fall bit period inside the zero window decodes as 0, and one inside the one window decodes as 1; both limits are inclusive. A period in neither window aborts the frame with no interrupt.
- R5: When bit1_en is low, a period that lies only in the one window aborts the frame.
- R6: Bits are shifted in least-significant bit first, so the first bit received lands in frame_o[0]. A frame completes after frame_len+1 bit periods. With frame_len = 31, a frame that stops after 31 bits produces no interrupt.
- R7: status_o bit 3 (valid) is set on every interrupt. Bit 1 is set when frame byte 1 is not the bitwise inverse of byte 0. Bit 2 is set when byte 3 is not the inverse of byte 2. Bit 0 is set only for repeat frames. status_o changes only together with an interrupt.
- R8: With hold_en high, a captured frame blocks later data frames (no interrupt, frame_o unchanged) until a frame_rd pulse.
- R9: A frame still in progress frame_max ticks after its leader edge is abandoned, and busy returns low.
- R10: While enable is low, nothing is decoded and busy stays low. A soft_rst pulse returns the decoder to idle on the next clock.
- R11: A change on ir_in_n is accepted only after it has held for filt_len+1 consecutive clocks. Shorter glitches have no effect.
- R12: irq is a single-cycle pulse. busy is high from an accepted leader edge until the frame ends or is dropped.
- R13: After reset, frame_o and status_o are zero and irq and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_in_n | input | 1 | Synchronised receiver line, low = mark |
| enable | input | 1 | Decoder enable |
| soft_rst | input | 1 | Return decoder to idle |
| base_div | input | 12 | Base tick = (base_div+1) microseconds |
| filt_len | input | 3 | Glitch filter length minus one, in clocks |
| ldr_mark_min | input | 13 | Leader mark lower limit, ticks |
| ldr_mark_max | input | 13 | Leader mark upper limit, ticks |
| ldr_space_min | input | 13 | Data leader space lower limit, ticks |
| ldr_space_max | input | 13 | Data leader space upper limit, ticks |
| rpt_space_min | input | 10 | Repeat leader space lower limit, ticks |
| rpt_space_max | input | 10 | Repeat leader space upper limit, ticks |
| bit0_min | input | 10 | Zero bit period lower limit, ticks |
| bit0_max | input | 10 | Zero bit period upper limit, ticks |
| bit1_min | input | 10 | One bit period lower limit, ticks |
| bit1_max | input | 10 | One bit period upper limit, ticks |
| bit1_en | input | 1 | Enable matching of one bits |
| frame_max | input | 13 | Frame time limit, ticks |
| frame_len | input | 5 | Bits per frame minus one |
| hold_en | input | 1 | Keep captured frame until read |
| frame_rd | input | 1 | Read strobe that releases a held frame |
| frame_o | output | 32 | Last captured frame |
| status_o | output | 4 | {valid, data error, custom error, repeat} |
| busy | output | 1 | Frame reception in progress |
| irq | output | 1 | One-cycle result pulse |

## Verification
The decoder's state mostly shows up at the ports late: a wrong bit count, a misclassified period or a shifted register only appears when the frame ends. It shows as a missing interrupt, a wrong frame word or wrong error bits. The bench therefore compares whole frames and the status captured at each interrupt, and counts interrupts per stimulus. A state machine left out of idle shows within a clock through busy, which is sampled after soft reset, after disable and after a frame is dropped. Window edges are driven at exactly the limit and one tick beyond it, so an off-by-one in the duration counters changes the interrupt count.

// File: rtl/ir_nec_pkg.sv
// Shared types for the infrared frame decoder.
// Assumes: the status bit positions below are decoded by the consumer.
package ir_nec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LMARK  = 2'd1,
        ST_LSPACE = 2'd2,
        ST_BITS   = 2'd3
    } rx_state_t;

    localparam int STAT_VALID = 3;
    localparam int STAT_DERR  = 2;
    localparam int STAT_CERR  = 1;
    localparam int STAT_RPT   = 0;
endpackage

// File: rtl/ir_tick_gen.sv
// Base tick generator: a microsecond strobe from CLK_PER_US clocks,
// then divided by base_div+1. Assumes base_div is static while enabled.
module ir_tick_gen #(
    parameter int CLK_PER_US = 50,
    parameter int DIV_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] base_div,
    output logic             tick
);
    logic             us_stb;
    logic [DIV_W-1:0] div_cnt;

    generate
        if (CLK_PER_US <= 1) begin : g_direct
            assign us_stb = 1'b1;
        end else begin : g_count
            localparam int UW = $clog2(CLK_PER_US);
            localparam logic [UW-1:0] US_LAST = UW'(CLK_PER_US - 1);
            logic [UW-1:0] us_cnt;
            // Purpose: count clocks within one microsecond.
            always_ff @(posedge clk) begin
                if (!rst_n || us_cnt == US_LAST) us_cnt <= '0;
                else                             us_cnt <= us_cnt + 1'b1;
            end
            assign us_stb = (us_cnt == US_LAST);
        end
    endgenerate

    // Purpose: count microseconds up to the programmed divider.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        div_cnt <= '0;
        else if (us_stb) begin
            if (div_cnt >= base_div) div_cnt <= '0;
            else                     div_cnt <= div_cnt + 1'b1;
        end
    end

    assign tick = us_stb && (div_cnt >= base_div);
endmodule

// File: rtl/ir_glitch_filter.sv
// Glitch filter: the output follows the input only after the input has
// differed from it for limit+1 consecutive clocks. Idle level is high.
module ir_glitch_filter #(
    parameter int FW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [FW-1:0] limit,
    input  logic          din,
    output logic          dout
);
    logic [FW-1:0] cnt;

    // Purpose: qualify each input change against the stability count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b1;
            cnt  <= '0;
        end else if (clr) begin
            dout <= din;
            cnt  <= '0;
        end else if (din == dout) begin
            cnt  <= '0;
        end else if (cnt >= limit) begin
            dout <= din;
            cnt  <= '0;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ir_nec_fsm.sv
// Frame state machine: measures edge-to-edge and fall-to-fall durations in
// base ticks, classifies them against the windows and shifts bits in LSB
// first. Emits one-cycle done pulses. Assumes a filtered, active-low line.
module ir_nec_fsm
    import ir_nec_pkg::*;
#(
    parameter int LW = 13,
    parameter int SW = 10,
    parameter int BW = 32,
    parameter int NW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic          line,
    input  logic [LW-1:0] mark_min,
    input  logic [LW-1:0] mark_max,
    input  logic [LW-1:0] space_min,
    input  logic [LW-1:0] space_max,
    input  logic [SW-1:0] rpt_min,
    input  logic [SW-1:0] rpt_max,
    input  logic [SW-1:0] b0_min,
    input  logic [SW-1:0] b0_max,
    input  logic [SW-1:0] b1_min,
    input  logic [SW-1:0] b1_max,
    input  logic          b1_en,
    input  logic [LW-1:0] frame_max,
    input  logic [NW-1:0] last_bit,
    output logic          busy,
    output logic          done_data,
    output logic          done_rpt,
    output logic [BW-1:0] word
);
    localparam int PADW = LW - SW;

    rx_state_t     state;
    logic          line_q;
    logic [LW-1:0] dur;
    logic [SW-1:0] per;
    logic [LW-1:0] ft;
    logic [NW-1:0] bitcnt;
    logic          fall, rise;
    logic          mark_hit, space_hit, rpt_hit, b0_hit, b1_hit, timeout;

    assign fall      = line_q & ~line;
    assign rise      = ~line_q & line;
    assign mark_hit  = (dur >= mark_min) && (dur <= mark_max);
    assign space_hit = (dur >= space_min) && (dur <= space_max);
    assign rpt_hit   = (dur >= {{PADW{1'b0}}, rpt_min}) &&
                       (dur <= {{PADW{1'b0}}, rpt_max});
    assign b0_hit    = (per >= b0_min) && (per <= b0_max);
    assign b1_hit    = b1_en && (per >= b1_min) && (per <= b1_max);
    assign timeout   = (ft > frame_max);
    assign busy      = (state != ST_IDLE);

    // Purpose: edge-to-edge, fall-to-fall and whole-frame tick counters.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            line_q <= 1'b1;
            dur    <= '0;
            per    <= '0;
            ft     <= '0;
        end else begin
            line_q <= line;
            if (fall || rise)         dur <= tick ? LW'(1) : '0;
            else if (tick && dur != '1) dur <= dur + 1'b1;
            if (fall)                 per <= tick ? SW'(1) : '0;
            else if (tick && per != '1) per <= per + 1'b1;
            if (state == ST_IDLE)     ft  <= '0;
            else if (tick && ft != '1)  ft  <= ft + 1'b1;
        end
    end

    // Purpose: frame sequencing, bit shifting and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            word      <= '0;
            done_data <= 1'b0;
            done_rpt  <= 1'b0;
        end else if (clr) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            done_data <= 1'b0;
            done_rpt  <= 1'b0;
        end else begin
            done_data <= 1'b0;
            done_rpt  <= 1'b0;
            unique case (state)
                ST_IDLE: if (fall) state <= ST_LMARK;
                ST_LMARK: if (rise) state <= mark_hit ? ST_LSPACE : ST_IDLE;
                ST_LSPACE: if (fall) begin
                    if (space_hit) begin
                        state  <= ST_BITS;
                        bitcnt <= '0;
                    end else begin
                        done_rpt <= rpt_hit;
                        state    <= ST_IDLE;
                    end
                end
                ST_BITS: if (fall) begin
                    if (b0_hit || b1_hit) begin
                        word <= {~b0_hit, word[BW-1:1]};
                        if (bitcnt == last_bit) begin
                            done_data <= 1'b1;
                            state     <= ST_IDLE;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (state != ST_IDLE && timeout) state <= ST_IDLE;
        end
    end
endmodule

// File: rtl/ir_nec_rx.sv
// Top of the infrared frame decoder: tick generator, glitch filter, frame
// state machine and the result stage (frame register, status, hold, irq).
// Assumes all configuration inputs are static while enable is high.
module ir_nec_rx
    import ir_nec_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int DIV_W      = 12,
    parameter int FILT_W     = 3,
    parameter int LW         = 13,
    parameter int SW         = 10,
    parameter int BW         = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_in_n,
    input  logic              enable,
    input  logic              soft_rst,
    input  logic [DIV_W-1:0]  base_div,
    input  logic [FILT_W-1:0] filt_len,
    input  logic [LW-1:0]     ldr_mark_min,
    input  logic [LW-1:0]     ldr_mark_max,
    input  logic [LW-1:0]     ldr_space_min,
    input  logic [LW-1:0]     ldr_space_max,
    input  logic [SW-1:0]     rpt_space_min,
    input  logic [SW-1:0]     rpt_space_max,
    input  logic [SW-1:0]     bit0_min,
    input  logic [SW-1:0]     bit0_max,
    input  logic [SW-1:0]     bit1_min,
    input  logic [SW-1:0]     bit1_max,
    input  logic              bit1_en,
    input  logic [LW-1:0]     frame_max,
    input  logic [$clog2(BW)-1:0] frame_len,
    input  logic              hold_en,
    input  logic              frame_rd,
    output logic [BW-1:0]     frame_o,
    output logic [3:0]        status_o,
    output logic              busy,
    output logic              irq
);
    localparam int NW = $clog2(BW);

    logic          clr, tick, line_f, done_data, done_rpt, held_q;
    logic [BW-1:0] word;
    logic          cust_err, data_err;

    assign clr = !enable || soft_rst;

    ir_tick_gen #(.CLK_PER_US(CLK_PER_US), .DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(clr), .base_div(base_div), .tick(tick)
    );

    ir_glitch_filter #(.FW(FILT_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .limit(filt_len),
        .din(ir_in_n), .dout(line_f)
    );

    ir_nec_fsm #(.LW(LW), .SW(SW), .BW(BW), .NW(NW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .line(line_f),
        .mark_min(ldr_mark_min), .mark_max(ldr_mark_max),
        .space_min(ldr_space_min), .space_max(ldr_space_max),
        .rpt_min(rpt_space_min), .rpt_max(rpt_space_max),
        .b0_min(bit0_min), .b0_max(bit0_max),
        .b1_min(bit1_min), .b1_max(bit1_max), .b1_en(bit1_en),
        .frame_max(frame_max), .last_bit(frame_len),
        .busy(busy), .done_data(done_data), .done_rpt(done_rpt), .word(word)
    );

    assign cust_err = (word[15:8]  != ~word[7:0]);
    assign data_err = (word[31:24] != ~word[23:16]);

    // Purpose: load frame and status, manage hold, pulse the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_o  <= '0;
            status_o <= '0;
            irq      <= 1'b0;
            held_q   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (frame_rd || !hold_en) held_q <= 1'b0;
            if (done_rpt) begin
                status_o           <= '0;
                status_o[STAT_VALID] <= 1'b1;
                status_o[STAT_RPT]   <= 1'b1;
                irq                <= 1'b1;
            end else if (done_data && !(hold_en && held_q)) begin
                frame_o              <= word;
                status_o[STAT_VALID] <= 1'b1;
                status_o[STAT_DERR]  <= data_err;
                status_o[STAT_CERR]  <= cust_err;
                status_o[STAT_RPT]   <= 1'b0;
                irq                  <= 1'b1;
                if (hold_en) held_q  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ir_nec_rx_chk.sv
// Checker for the infrared frame decoder, attached by bind.
module ir_nec_rx_chk #(
    parameter int BW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          soft_rst,
    input logic          hold_en,
    input logic          frame_rd,
    input logic          held_q,
    input logic [BW-1:0] frame_o,
    input logic [3:0]    status_o,
    input logic          busy,
    input logic          irq
);
    // R12: interrupt lasts one cycle
    p_irq_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R12: every interrupt follows a busy period
    p_irq_after_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(busy, 2));

    // R10: disable or soft reset idles the decoder
    p_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || soft_rst) |=> !busy);

    // R3: a repeat result leaves the frame register alone
    p_rpt_keeps_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && status_o[0]) |-> $stable(frame_o));

    // R7: valid accompanies every interrupt
    p_irq_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status_o[3]);

    // R7: status only moves with an interrupt
    p_status_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> $stable(status_o));

    // R7: custom-code error matches the captured address bytes
    p_cust_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !status_o[0]) |-> (status_o[1] == (frame_o[15:8] != ~frame_o[7:0])));

    // R8: a held frame is not overwritten
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_en && held_q && !frame_rd) |=> $stable(frame_o));
endmodule

bind ir_nec_rx ir_nec_rx_chk #(.BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
    .hold_en(hold_en), .frame_rd(frame_rd), .held_q(held_q),
    .frame_o(frame_o), .status_o(status_o), .busy(busy), .irq(irq)
);

// File: tb/ir_nec_rx_tb.sv
`timescale 1ns/1ps
// Bench: one clock per microsecond so that, with base_div 0, a tick is a clock.
module ir_nec_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_in_n = 1'b1;
    logic        enable = 1'b1;
    logic        soft_rst = 1'b0;
    logic [11:0] base_div = '0;
    logic [2:0]  filt_len = 3'd2;
    logic [12:0] ldr_mark_min = 13'd400, ldr_mark_max = 13'd500;
    logic [12:0] ldr_space_min = 13'd200, ldr_space_max = 13'd300;
    logic [9:0]  rpt_space_min = 10'd80, rpt_space_max = 10'd150;
    logic [9:0]  bit0_min = 10'd40, bit0_max = 10'd72;
    logic [9:0]  bit1_min = 10'd90, bit1_max = 10'd134;
    logic        bit1_en = 1'b1;
    logic [12:0] frame_max = 13'd4000;
    logic [4:0]  frame_len = 5'd31;
    logic        hold_en = 1'b0;
    logic        frame_rd = 1'b0;
    logic [31:0] frame_o;
    logic [3:0]  status_o;
    logic        busy, irq;

    always #10 clk = ~clk;

    ir_nec_rx #(.CLK_PER_US(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .ir_in_n(ir_in_n), .enable(enable),
        .soft_rst(soft_rst), .base_div(base_div), .filt_len(filt_len),
        .ldr_mark_min(ldr_mark_min), .ldr_mark_max(ldr_mark_max),
        .ldr_space_min(ldr_space_min), .ldr_space_max(ldr_space_max),
        .rpt_space_min(rpt_space_min), .rpt_space_max(rpt_space_max),
        .bit0_min(bit0_min), .bit0_max(bit0_max),
        .bit1_min(bit1_min), .bit1_max(bit1_max), .bit1_en(bit1_en),
        .frame_max(frame_max), .frame_len(frame_len),
        .hold_en(hold_en), .frame_rd(frame_rd),
        .frame_o(frame_o), .status_o(status_o), .busy(busy), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;
    int irq_cnt = 0;
    logic [31:0] cap_frame = '0;
    logic [3:0]  cap_stat = '0;
    logic busy_seen = 1'b0, irq_prev = 1'b0, wide_irq = 1'b0;

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (irq) begin
            irq_cnt++;
            cap_frame = frame_o;
            cap_stat  = status_o;
        end
        if (irq && irq_prev) wide_irq = 1'b1;
        irq_prev = irq;
        if (busy) busy_seen = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic lvl, input int n);
        ir_in_n = lvl;
        repeat (n) @(negedge clk);
    endtask

    // Leader, nb bit periods (28-cycle mark each), optional stop mark, idle.
    task automatic send(input logic [31:0] w, input bit rpt, input int sc,
                        input int lm, input int ls, input int b0, input int b1,
                        input int nb, input bit stop);
        drive(1'b0, lm * sc);
        drive(1'b1, ls * sc);
        if (!rpt) for (int i = 0; i < nb; i++) begin
            drive(1'b0, 28 * sc);
            drive(1'b1, ((w[i] ? b1 : b0) - 28) * sc);
        end
        if (stop) begin
            drive(1'b0, 28 * sc);
            drive(1'b1, 60);
        end
    endtask

    typedef struct packed {
        logic [31:0] word;
        logic        rpt;
        logic        div;
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic        exp_irq;
        logic [3:0]  exp_st;
        logic [31:0] exp_word;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{32'hEF10BF40, 1'b0, 1'b0, 8'd56, 8'd112, 1'b1, 4'h8, 32'hEF10BF40, 4'd6}, // R6 LSB first
        '{32'h00FF00FF, 1'b0, 1'b0, 8'd56, 8'd112, 1'b1, 4'h8, 32'h00FF00FF, 4'd7}, // R7 clean
        '{32'hE51A3412, 1'b0, 1'b0, 8'd56, 8'd112, 1'b1, 4'hA, 32'hE51A3412, 4'd7}, // R7 custom err
        '{32'h0000FF00, 1'b0, 1'b0, 8'd56, 8'd112, 1'b1, 4'hC, 32'h0000FF00, 4'd7}, // R7 data err
        '{32'h00000000, 1'b0, 1'b0, 8'd56, 8'd112, 1'b1, 4'hE, 32'h00000000, 4'd7}, // R7 both
        '{32'h00000000, 1'b1, 1'b0, 8'd56, 8'd112, 1'b1, 4'h9, 32'h00000000, 4'd3}, // R3 repeat
        '{32'hFE017F80, 1'b0, 1'b1, 8'd56, 8'd112, 1'b1, 4'h8, 32'hFE017F80, 4'd1}, // R1 div 1
        '{32'h00000000, 1'b1, 1'b1, 8'd56, 8'd112, 1'b1, 4'h9, 32'hFE017F80, 4'd3}, // R3 repeat div 1
        '{32'hF708FB04, 1'b0, 1'b0, 8'd40, 8'd112, 1'b1, 4'h8, 32'hF708FB04, 4'd4}, // R4 zero min
        '{32'h6B94F20D, 1'b0, 1'b0, 8'd72, 8'd112, 1'b1, 4'h8, 32'h6B94F20D, 4'd4}, // R4 zero max
        '{32'h01FEFD02, 1'b0, 1'b0, 8'd56, 8'd134, 1'b1, 4'h8, 32'h01FEFD02, 4'd4}, // R4 one max
        '{32'h7F80FE01, 1'b0, 1'b0, 8'd56, 8'd90,  1'b1, 4'h8, 32'h7F80FE01, 4'd4}, // R4 one min
        '{32'h00000000, 1'b0, 1'b0, 8'd73, 8'd112, 1'b0, 4'h8, 32'h7F80FE01, 4'd4}, // R4 zero+1 aborts
        '{32'h00000000, 1'b0, 1'b0, 8'd39, 8'd112, 1'b0, 4'h8, 32'h7F80FE01, 4'd4}, // R4 zero-1 aborts
        '{32'h7F80FE01, 1'b0, 1'b0, 8'd56, 8'd135, 1'b0, 4'h8, 32'h7F80FE01, 4'd4}  // R4 one+1 aborts
    };

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        chk(frame_o == 32'h0, "R13 frame", frame_o, 32'h0);
        chk(status_o == 4'h0, "R13 status", {28'h0, status_o}, 32'h0);
        chk(!busy && !irq, "R13 busy/irq", {30'h0, busy, irq}, 32'h0);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = TBL[i];
            tag = $sformatf("R%0d vec%0d", v.req, i);
            base_div = {11'h0, v.div};
            c0 = irq_cnt;
            send(v.word, v.rpt, v.div ? 2 : 1, 450, v.rpt ? 112 : 225, v.b0, v.b1, 32, 1'b1);
            chk((irq_cnt - c0) == int'(v.exp_irq), {tag, " irq count"}, irq_cnt - c0, {31'h0, v.exp_irq});
            if (v.exp_irq) begin
                chk(cap_frame == v.exp_word, {tag, " frame"}, cap_frame, v.exp_word);
                chk(cap_stat == v.exp_st, {tag, " status"}, {28'h0, cap_stat}, {28'h0, v.exp_st});
            end else begin
                chk(frame_o == v.exp_word, {tag, " frame kept"}, frame_o, v.exp_word);
            end
            chk(!busy, {tag, " idle after"}, {31'h0, busy}, 32'h0);
        end
        base_div = '0;

        // R2: leader mark too short and too long.
        c0 = irq_cnt;
        send(32'hEF10BF40, 1'b0, 1, 380, 225, 56, 112, 32, 1'b1);
        send(32'hEF10BF40, 1'b0, 1, 520, 225, 56, 112, 32, 1'b1);
        chk(irq_cnt == c0, "R2 bad leader mark", irq_cnt - c0, 0);
        chk(!busy, "R2 idle", {31'h0, busy}, 32'h0);

        // R3: leader space between both windows is dropped.
        c0 = irq_cnt;
        send(32'hEF10BF40, 1'b0, 1, 450, 175, 56, 112, 32, 1'b1);
        chk(irq_cnt == c0, "R3 odd space", irq_cnt - c0, 0);

        // R5: one bits rejected while bit1_en is low.
        bit1_en = 1'b0;
        c0 = irq_cnt;
        send(32'h7F80FE01, 1'b0, 1, 450, 225, 56, 112, 32, 1'b1);
        chk(irq_cnt == c0, "R5 one disabled", irq_cnt - c0, 0);
        chk(frame_o == 32'h7F80FE01, "R5 frame kept", frame_o, 32'h7F80FE01);
        bit1_en = 1'b1;

        // R6 / R9: a 31-bit frame stalls, then the frame timer drops it.
        c0 = irq_cnt;
        send(32'h00FF00FF, 1'b0, 1, 450, 225, 56, 112, 31, 1'b1);
        chk(busy, "R6 waits for last bit", {31'h0, busy}, 32'h1);
        repeat (1500) @(negedge clk);
        chk(irq_cnt == c0, "R6 short frame", irq_cnt - c0, 0);
        chk(!busy, "R9 timer drop", {31'h0, busy}, 32'h0);

        // R9: frame limit shorter than a frame.
        frame_max = 13'd1000;
        c0 = irq_cnt;
        send(32'hEF10BF40, 1'b0, 1, 450, 225, 56, 112, 32, 1'b1);
        chk(irq_cnt == c0, "R9 frame too long", irq_cnt - c0, 0);
        frame_max = 13'd4000;

        // R8: hold mode.
        hold_en = 1'b1;
        c0 = irq_cnt;
        send(32'hEF10BF40, 1'b0, 1, 450, 225, 56, 112, 32, 1'b1);
        chk(irq_cnt == c0 + 1 && frame_o == 32'hEF10BF40, "R8 first capture", frame_o, 32'hEF10BF40);
        send(32'h00FF00FF, 1'b0, 1, 450, 225, 56, 112, 32, 1'b1);
        chk(irq_cnt == c0 + 1, "R8 blocked irq", irq_cnt - c0, 1);
        chk(frame_o == 32'hEF10BF40, "R8 frame held", frame_o, 32'hEF10BF40);
        frame_rd = 1'b1;
        @(negedge clk);
        frame_rd = 1'b0;
        send(32'h00FF00FF, 1'b0, 1, 450, 225, 56, 112, 32, 1'b1);
        chk(irq_cnt == c0 + 2 && frame_o == 32'h00FF00FF, "R8 after read", frame_o, 32'h00FF00FF);
        hold_en = 1'b0;

        // R10: disabled decoder ignores a frame.
        enable = 1'b0;
        busy_seen = 1'b0;
        c0 = irq_cnt;
        send(32'hEF10BF40, 1'b0, 1, 450, 225, 56, 112, 32, 1'b1);
        chk(irq_cnt == c0 && !busy_seen, "R10 disabled", {31'h0, busy_seen}, 32'h0);
        enable = 1'b1;

        // R10: soft reset mid-frame.
        c0 = irq_cnt;
        send(32'hEF10BF40, 1'b0, 1, 450, 225, 56, 112, 10, 1'b0);
        chk(busy, "R10 busy mid-frame", {31'h0, busy}, 32'h1);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk(!busy, "R10 soft reset idles", {31'h0, busy}, 32'h0);
        repeat (200) @(negedge clk);
        chk(irq_cnt == c0, "R10 no result", irq_cnt - c0, 0);

        // R11: glitch filter.
        filt_len = 3'd7;
        repeat (10) @(negedge clk);
        busy_seen = 1'b0;
        drive(1'b0, 5);
        drive(1'b1, 30);
        chk(!busy_seen, "R11 glitch rejected", {31'h0, busy_seen}, 32'h0);
        drive(1'b0, 12);
        drive(1'b1, 30);
        chk(busy_seen, "R11 long pulse accepted", {31'h0, busy_seen}, 32'h1);
        chk(!busy, "R11 short mark dropped", {31'h0, busy}, 32'h0);
        c0 = irq_cnt;
        send(32'hB44BF20D, 1'b0, 1, 450, 225, 56, 112, 32, 1'b1);
        chk(irq_cnt == c0 + 1 && cap_frame == 32'hB44BF20D, "R11 frame through filter", cap_frame, 32'hB44BF20D);
        filt_len = 3'd2;

        // R12: interrupt width over the whole run.
        chk(!wide_irq, "R12 irq one cycle", {31'h0, wide_irq}, 32'h0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule